// File: doc/BRIEF.md
# Byte Lane Steering Bridge

This bridge joins a CPU that drives a 16-bit multiplexed address/data bus to a local memory split into an even bank and an odd bank. It also joins the CPU to a system bus that returns byte operands only on its low-order lane. In the even/odd scheme used here, an even byte address lives in the high-order lane of a word and an odd byte address lives in the low-order lane.

On a transfer request the bridge decodes the bank enables with no added delay. A byte transfer turns on only the bank named by address bit 0. A word transfer turns on both banks. Write data is forwarded unchanged: the CPU already repeats a byte operand on both lanes, so either bank can take it. The address is forwarded unchanged as well.

For reads, the bridge registers a swap decision when the request is accepted. When the returned data is marked valid, it registers the data toward the CPU. An even-address byte read has its low byte copied onto every lane, which puts the operand in the high-order lane the CPU reads. Odd-address byte reads and word reads pass through untouched. Software cannot see the swap and has no way to control it.

Top module: `byte_lane_bridge`

## Requirements
- R1: `mem_we` is 1 exactly when `cpu_req` is 1 and `cpu_rd` is 0 (a write); it is 0 for reads and idle cycles.
- R2: During a request with `cpu_byte`=1 and `cpu_addr[0]`=1, `bank_odd_en`=1 and `bank_even_en`=0, for both reads and writes.
- R3: During a request with `cpu_byte`=1 and `cpu_addr[0]`=0, `bank_even_en`=1 and `bank_odd_en`=0, for both reads and writes.
- R4: During a request with `cpu_byte`=0 (word), both bank enables are 1; with `cpu_req`=0, both are 0.
- R5: `mem_wdata` always equals `cpu_wdata` and `mem_addr` always equals `cpu_addr`, bit for bit, with no lane steering.
- R6: After a read request with `cpu_byte`=1 and `cpu_addr[0]`=0, the next `sys_rvalid` cycle yields, one clock later, `cpu_rdata` = {sys_rdata[7:0], sys_rdata[7:0]}.
- R7: After a byte read request at an odd address, or after a word read request, the next `sys_rvalid` cycle yields, one clock later, `cpu_rdata` = `sys_rdata` unchanged.
- R8: `cpu_rvalid` equals `sys_rvalid` delayed by one clock; in a cycle after `sys_rvalid`=0, `cpu_rdata` keeps its previous value.
- R9: While `rst_n`=0 and in the first cycle after reset, `cpu_rvalid`=0 and `cpu_rdata`=0; before any read request, returned data is not swapped.
- R10: Only a read request updates the swap decision. Write requests and idle cycles leave it as it is. If a read request and `sys_rvalid` fall in the same cycle, that returned data uses the decision from the earlier read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Transfer request this cycle |
| cpu_rd | input | 1 | 1 = read, 0 = write |
| cpu_byte | input | 1 | 1 = byte transfer, 0 = word transfer |
| cpu_addr | input | ADDR_W | Transfer address; bit 0 picks the byte lane |
| cpu_wdata | input | DATA_W | Write data from the CPU (byte repeated on both lanes) |
| mem_addr | output | ADDR_W | Address to local memory |
| mem_wdata | output | DATA_W | Write data to local memory |
| mem_we | output | 1 | Memory write strobe |
| bank_even_en | output | 1 | Enable for the even (high-lane) bank |
| bank_odd_en | output | 1 | Enable for the odd (low-lane) bank |
| sys_rvalid | input | 1 | Returned read data valid |
| sys_rdata | input | DATA_W | Returned read data; bytes arrive on bits 7:0 |
| cpu_rvalid | output | 1 | Steered read data valid (one clock after `sys_rvalid`) |
| cpu_rdata | output | DATA_W | Steered read data to the CPU |

## Verification
The bench builds the block with DATA_W=16 and LANE_W=8, which is the two-lane case the steering depends on. It narrows ADDR_W to 8, so random addresses exercise both values of bit 0 often and the address pass-through is checked across its whole width. With these values, a reference model that uses only the requirements can predict every enable, strobe and returned word on every clock. That includes reads that overlap later requests and the case where a request and returned data fall in the same cycle.

// File: rtl/blsb_pkg.sv
package blsb_pkg;

  typedef struct packed {
    logic even;
    logic odd;
  } bank_sel_t;

  // Bank selection for one request: byte picks one bank by the lane bit,
  // word picks both, no request picks none.
  function automatic bank_sel_t pick_banks(input logic req,
                                           input logic is_byte,
                                           input logic lane_bit);
    bank_sel_t s;
    s.even = req & (~is_byte | ~lane_bit);
    s.odd  = req & (~is_byte |  lane_bit);
    return s;
  endfunction

  // A read of a byte from the even (high-order) lane needs the returned
  // low byte copied upward.
  function automatic logic needs_swap(input logic is_rd,
                                      input logic is_byte,
                                      input logic lane_bit);
    return is_rd & is_byte & ~lane_bit;
  endfunction

endpackage

// File: rtl/blsb_bank_decode.sv
module blsb_bank_decode
  import blsb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic is_rd,
  input  logic is_byte,
  input  logic lane_bit,
  output logic even_en,
  output logic odd_en,
  output logic we
);

  bank_sel_t sel;

  always_comb begin
    sel     = pick_banks(req, is_byte, lane_bit);
    even_en = sel.even;
    odd_en  = sel.odd;
    we      = req & ~is_rd;
  end

  // R2
  odd_lane_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && is_byte && lane_bit) |-> (odd_en && !even_en));

  // R3
  even_lane_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && is_byte && !lane_bit) |-> (even_en && !odd_en));

  // R4
  idle_no_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (!even_en && !odd_en && !we));

endmodule

// File: rtl/blsb_swap_ctrl.sv
module blsb_swap_ctrl
  import blsb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic is_rd,
  input  logic is_byte,
  input  logic lane_bit,
  output logic swap_q
);

  logic rd_accept;
  logic swap_next;

  assign rd_accept = req & is_rd;
  assign swap_next = needs_swap(is_rd, is_byte, lane_bit);

  always_ff @(posedge clk) begin
    if (!rst_n)         swap_q <= 1'b0;
    else if (rd_accept) swap_q <= swap_next;
  end

  // R10
  swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_accept |=> $stable(swap_q));

endmodule

// File: rtl/blsb_read_steer.sv
module blsb_read_steer #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int NUM_LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] steered;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign steered[g*LANE_W +: LANE_W] =
      swap ? in_data[LANE_W-1:0] : in_data[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= steered;
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R6
  swap_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && swap) |=> (out_data[DATA_W-1 -: LANE_W] == out_data[LANE_W-1:0]));

endmodule

// File: rtl/byte_lane_bridge.sv
module byte_lane_bridge #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_rd,
  input  logic              cpu_byte,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              bank_even_en,
  output logic              bank_odd_en,
  input  logic              sys_rvalid,
  input  logic [DATA_W-1:0] sys_rdata,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata
);

  logic lane_bit;
  logic swap_active;

  assign lane_bit  = cpu_addr[0];
  assign mem_addr  = cpu_addr;
  assign mem_wdata = cpu_wdata;

  blsb_bank_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (cpu_req),
    .is_rd    (cpu_rd),
    .is_byte  (cpu_byte),
    .lane_bit (lane_bit),
    .even_en  (bank_even_en),
    .odd_en   (bank_odd_en),
    .we       (mem_we)
  );

  blsb_swap_ctrl u_swap (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (cpu_req),
    .is_rd    (cpu_rd),
    .is_byte  (cpu_byte),
    .lane_bit (lane_bit),
    .swap_q   (swap_active)
  );

  blsb_read_steer #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap      (swap_active),
    .in_valid  (sys_rvalid),
    .in_data   (sys_rdata),
    .out_valid (cpu_rvalid),
    .out_data  (cpu_rdata)
  );

  // R7
  word_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_rd && !cpu_byte) |=> !swap_active);

  // R1
  write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_rd) |-> !mem_we);

endmodule

// File: tb/tb_byte_lane_bridge.sv
module tb_byte_lane_bridge;
  localparam int DW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_rd = 1'b0, cpu_byte = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          sys_rvalid = 1'b0;
  logic [DW-1:0] sys_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we, bank_even_en, bank_odd_en, cpu_rvalid;
  logic [DW-1:0] cpu_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  bit        m_swap = 1'b0;
  bit        m_rvalid = 1'b0;
  bit [15:0] m_rdata = '0;

  always #10 clk = ~clk;

  byte_lane_bridge #(.DATA_W(DW), .ADDR_W(AW), .LANE_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_rd(cpu_rd),
    .cpu_byte(cpu_byte), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .bank_even_en(bank_even_en), .bank_odd_en(bank_odd_en),
    .sys_rvalid(sys_rvalid), .sys_rdata(sys_rdata),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Model: returned data uses the decision held before this edge (R10).
  always @(posedge clk) begin
    if (!rst_n) begin
      m_swap = 0; m_rvalid = 0; m_rdata = '0;
    end else begin
      m_rvalid = sys_rvalid;
      if (sys_rvalid)
        m_rdata = m_swap ? {sys_rdata[7:0], sys_rdata[7:0]} : sys_rdata;
      if (cpu_req && cpu_rd)
        m_swap = cpu_byte && (cpu_addr % 2 == 0);
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (!done) begin
      bit exp_even, exp_odd;
      exp_even = cpu_req && (!cpu_byte || cpu_addr[0] == 1'b0);
      exp_odd  = cpu_req && (!cpu_byte || cpu_addr[0] == 1'b1);
      check("R1 mem_we", mem_we, cpu_req && !cpu_rd);
      if (cpu_req && cpu_byte && cpu_addr[0])  check("R2 banks", {bank_even_en, bank_odd_en}, 2'b01);
      else if (cpu_req && cpu_byte)            check("R3 banks", {bank_even_en, bank_odd_en}, 2'b10);
      else                                     check("R4 banks", {bank_even_en, bank_odd_en}, {exp_even, exp_odd});
      check("R5 wdata", mem_wdata, cpu_wdata);
      check("R5 addr", mem_addr, cpu_addr);
      check("R8 rvalid", cpu_rvalid, m_rvalid);
      check("R6/R7/R10 rdata", cpu_rdata, m_rdata);
    end
  end

  task automatic cyc(input bit req, input bit rd, input bit by, input logic [AW-1:0] a,
                     input logic [DW-1:0] wd, input bit rv, input logic [DW-1:0] rdat);
    @(posedge clk); #2;
    cpu_req = req; cpu_rd = rd; cpu_byte = by; cpu_addr = a;
    cpu_wdata = wd; sys_rvalid = rv; sys_rdata = rdat;
  endtask

  initial begin
    #5000000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset rvalid", cpu_rvalid, 0);
    check("R9 reset rdata", cpu_rdata, 0);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R9 post-reset rdata", cpu_rdata, 0);
    // R9: data before any read request is not swapped
    cyc(0,0,0,8'h00,16'h0,1,16'h3C5A);
    // byte writes odd/even, word write
    cyc(1,0,1,8'h11,16'h7777,0,0);   // R2
    cyc(1,0,1,8'h10,16'h4242,0,0);   // R3
    cyc(1,0,0,8'h20,16'hBEEF,0,0);   // R4
    // R6 even byte read
    cyc(1,1,1,8'h30,0,0,0);
    cyc(0,0,0,0,0,1,16'h00A5);
    // R7 odd byte read
    cyc(1,1,1,8'h31,0,0,0);
    cyc(0,0,0,0,0,1,16'h12C3);
    // R7 word read
    cyc(1,1,0,8'h32,0,0,0);
    cyc(0,0,0,0,0,1,16'h9A5B);
    // R10 writes between even read and return leave swap alone
    cyc(1,1,1,8'h40,0,0,0);
    cyc(1,0,1,8'h41,16'h1111,0,0);
    cyc(1,0,0,8'h42,16'h2222,0,0);
    cyc(0,0,0,0,0,1,16'h5566);
    // R10 read request and return in the same cycle: old decision used
    cyc(1,1,0,8'h50,0,1,16'hAB01);   // still swapped from even read
    cyc(1,1,1,8'h52,0,1,16'hCD02);   // word decision: no swap
    cyc(0,0,0,0,0,1,16'hEF03);       // even decision: swap
    // R8 hold with no valid
    cyc(0,0,0,0,0,0,16'hFFFF);
    cyc(0,0,0,0,0,0,16'h0000);
    // random traffic
    for (int i = 0; i < 400; i++)
      cyc($urandom%2, $urandom%2, $urandom%2, AW'($urandom), DW'($urandom),
          $urandom%2, DW'($urandom));
    cyc(0,0,0,0,0,0,0);
    @(posedge clk); @(negedge clk); #1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule